// File: doc/BRIEF.md
# Four-Bit Bit-Serial Adder

This block adds two 4-bit operands and a carry-in with one full-adder cell that is reused on every clock. A one-cycle start pulse captures both operands in parallel into two shift registers and sets the carry flip-flop from the carry-in. On each of the next four clocks the lowest remaining bit of each operand goes through the full adder, starting with the least significant bit. The sum bit enters the result register at its top end, and the carry-out is stored for the next bit.

After the fourth step a done flag rises. The result register then holds the low four bits of the total, and the carry output holds the fifth bit. Shifting stops until the next start. A start that arrives while an addition is running abandons that addition and begins a new one.

Top module: `bitser_add`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next cycle shows sum = 0, cout = 0 and done = 0.
- R2: If start is high at clock edge E and low afterwards, done is 0 after edges E+1 through E+3 and is 1 after edge E+4.
- R3: When done is 1, sum equals bits [3:0] of op_a + op_b + cin, using the values sampled at the start edge.
- R4: When done is 1, cout equals bit 4 of op_a + op_b + cin, using the values sampled at the start edge.
- R5: While done is 1 and start is low, further clocks leave sum, cout and done unchanged.
- R6: A start pulse that arrives during a running addition restarts the block. done is 0 after that edge, and the new result appears four edges later.
- R7: op_a, op_b and cin have no effect on the result when start is low.
- R8: At the start edge the carry flip-flop takes the value of cin. Setting cin to 1 adds one to the total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load operands and carry, then begin four bit steps |
| op_a | input | 4 | First operand, sampled when start is high |
| op_b | input | 4 | Second operand, sampled when start is high |
| cin | input | 1 | Carry into bit 0, sampled when start is high |
| sum | output | 4 | Result register, valid when done is 1 |
| cout | output | 1 | Carry out of bit 3, valid when done is 1 |
| done | output | 1 | High once the fourth bit step has finished |

## Verification
A table of operand pairs covers several cases, and each one separates a different kind of fault:
- all-zero operands;
- all-ones operands with carry-in set, so a carry passes through every bit;
- complementary patterns such as A plus 5, where no carry occurs unless cin is 1;
- sums that land exactly on 16, which show whether cout is taken from the correct stored carry.

Directed tests follow the table. One holds the clock after done to catch stray shifting. One changes the operands after the start edge. One restarts the block in the middle of an addition. One asserts reset mid-run.

// File: rtl/bsa_pkg.sv
// Package bsa_pkg: shared types and counts for the bit-serial adder.
// Assumes one operand register per addend; two addends in total.
package bsa_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } step_st_e;

    localparam int unsigned OPND_N = 2;
endpackage

// File: rtl/fa_cell.sv
// Module fa_cell: single-bit full adder, purely combinational.
// Assumes inputs are stable for the cycle; no state is held here.
module fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Sum and carry of three input bits
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/opnd_piso.sv
// Module opnd_piso: parallel-load operand register that shifts toward bit 0.
// Assumes load has priority over shift; the serial output is always bit 0.
module opnd_piso #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] pin,
    output logic         sout
);
    logic [W-1:0] q;

    // Capture the operand or move it one place toward the LSB
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= pin;
        else if (shift)
            q <= {1'b0, q[W-1:1]};
    end

    assign sout = q[0];

    // R3
    load_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sout == $past(pin[0]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sout));
endmodule

// File: rtl/res_sipo.sv
// Module res_sipo: result register. Serial bits enter at the MSB and move
// toward bit 0, so that after W steps the first bit in ends up in bit 0.
// Assumes clr and shift are never both high (clr wins if they are).
module res_sipo #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] pout
);
    // Clear on a new load, otherwise take one sum bit per step
    always_ff @(posedge clk) begin
        if (!rst_n)
            pout <= '0;
        else if (clr)
            pout <= '0;
        else if (shift)
            pout <= {sin, pout[W-1:1]};
    end

    // R3
    msb_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clr) |=> pout[W-1] == $past(sin));

    // R5
    no_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clr) |=> $stable(pout));
endmodule

// File: rtl/step_ctl.sv
// Module step_ctl: sequences W bit steps after a load and raises done when
// they finish. Assumes load has priority and restarts the count.
module step_ctl
    import bsa_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic shift,
    output logic done
);
    localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    step_st_e      st;
    logic [CW-1:0] cnt;

    // State, step count and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b0;
        end else if (load) begin
            st   <= ST_RUN;
            cnt  <= '0;
            done <= 1'b0;
        end else if (st == ST_RUN) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                st   <= ST_IDLE;
                done <= 1'b1;
            end
        end
    end

    // A step occurs on every running cycle without a new load
    assign shift = (st == ST_RUN) && !load;

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shift || load) && !done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !shift);

    // R2
    last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && cnt == LAST) |=> (done || load));
endmodule

// File: rtl/bitser_add.sv
// Module bitser_add: adds two W-bit operands one bit per clock through one
// shared full adder, with a carry flip-flop between bit steps.
// Assumes start is a single-cycle pulse. Results are valid only while done is 1.
module bitser_add
    import bsa_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         done
);
    logic [W-1:0]        opnd_in [OPND_N];
    logic [OPND_N-1:0]   ser_bit;
    logic                step;
    logic                carry_q;
    logic                fa_s;
    logic                fa_c;

    assign opnd_in[0] = op_a;
    assign opnd_in[1] = op_b;

    // One operand shift register per addend
    for (genvar g = 0; g < OPND_N; g++) begin : g_opnd
        opnd_piso #(.W(W)) u_opnd (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (start),
            .shift (step),
            .pin   (opnd_in[g]),
            .sout  (ser_bit[g])
        );
    end

    step_ctl #(.W(W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .shift (step),
        .done  (done)
    );

    fa_cell u_fa (
        .a_i (ser_bit[0]),
        .b_i (ser_bit[1]),
        .c_i (carry_q),
        .s_o (fa_s),
        .c_o (fa_c)
    );

    res_sipo #(.W(W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .shift (step),
        .sin   (fa_s),
        .pout  (sum)
    );

    // Carry flip-flop: seeded from cin, then passes each bit's carry on
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (start)
            carry_q <= cin;
        else if (step)
            carry_q <= fa_c;
    end

    assign cout = carry_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (sum == '0 && !cout && !done));

    // R8
    carry_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cout == $past(cin));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sum) && $stable(cout)));

    // R6
    start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);
endmodule

// File: tb/sim_bitser_add.sv
module sim_bitser_add;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic       cin = 1'b0;
    logic [3:0] sum;
    logic       cout;
    logic       done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bitser_add #(.W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
        .op_b(op_b), .cin(cin), .sum(sum), .cout(cout), .done(done)
    );

    // {a, b, cin, expected 5-bit total}
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {4'h0, 4'h0, 1'b0, 5'd0},
        {4'hF, 4'hF, 1'b1, 5'd31},
        {4'hF, 4'h1, 1'b0, 5'd16},
        {4'hA, 4'h5, 1'b0, 5'd15},
        {4'hA, 4'h5, 1'b1, 5'd16},
        {4'h7, 4'h8, 1'b0, 5'd15},
        {4'h3, 4'h4, 1'b1, 5'd8},
        {4'h9, 4'h9, 1'b0, 5'd18},
        {4'hC, 4'h6, 1'b1, 5'd19},
        {4'h1, 4'hE, 1'b0, 5'd15},
        {4'h8, 4'h8, 1'b1, 5'd17},
        {4'h0, 4'hF, 1'b1, 5'd16}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Pulse start for one cycle; returns at the negedge after the load edge
    task automatic kick(input logic [3:0] a, input logic [3:0] b, input logic c);
        @(negedge clk);
        op_a = a; op_b = b; cin = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits four steps; returns 1 if done stayed low for three and rose on the fourth
    task automatic wait_done(output bit timing_ok);
        timing_ok = (done === 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (done !== 1'b0) timing_ok = 1'b0;
        end
        @(negedge clk);
        if (done !== 1'b1) timing_ok = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [3:0] s_hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sum", 32'(sum), 0);
        chk("R1 cout", 32'(cout), 0);
        chk("R1 done", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 timing, R3 sum, R4 carry out
        for (int k = 0; k < NV; k++) begin
            kick(VEC[k][13:10], VEC[k][9:6], VEC[k][5]);
            wait_done(ok);
            chk("R2 done timing", 32'(ok), 1);
            chk("R3 sum", 32'(sum), 32'(VEC[k][3:0]));
            chk("R4 cout", 32'(cout), 32'(VEC[k][4]));
        end

        // R8: carry-in alone propagates through all ones
        kick(4'hF, 4'h0, 1'b1);
        wait_done(ok);
        chk("R8 sum", 32'(sum), 0);
        chk("R8 cout", 32'(cout), 1);

        // R5: result holds after done
        s_hold = sum;
        repeat (6) @(negedge clk);
        chk("R5 sum hold", 32'(sum), 32'(s_hold));
        chk("R5 cout hold", 32'(cout), 1);
        chk("R5 done hold", 32'(done), 1);

        // R7: inputs changed after the load edge are ignored
        kick(4'h3, 4'h5, 1'b0);
        op_a = 4'hF; op_b = 4'hF; cin = 1'b1;
        wait_done(ok);
        chk("R7 sum", 32'(sum), 8);
        chk("R7 cout", 32'(cout), 0);

        // R6: restart in the middle of an addition
        kick(4'hF, 4'hF, 1'b1);
        @(negedge clk);
        op_a = 4'h1; op_b = 4'h2; cin = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 done cleared", 32'(done), 0);
        wait_done(ok);
        chk("R6 restart timing", 32'(ok), 1);
        chk("R6 sum", 32'(sum), 3);
        chk("R6 cout", 32'(cout), 0);

        // R1: reset mid-run
        kick(4'hF, 4'hF, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid sum", 32'(sum), 0);
        chk("R1 mid done", 32'(done), 0);
        chk("R1 mid cout", 32'(cout), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 idle after reset", 32'(done), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule